// File: doc/BRIEF.md
# Prescaled PWM Timer Channel

This block is one timer channel that turns a 16-bit up-counter into a pulse-width-modulated pin. The counter advances on a clock-enable tick taken from the system clock through a divider whose ratio steps in powers of four, runs from zero up to a programmable period value and then starts over. A compare value splits each period into an inactive first part and an active second part. A polarity bit can invert both levels.

Software reaches the channel through a plain register write port and a combinational read port. The registers hold the counter, the compare value, the period value and a control word. Output enable and counter enable are separate bits, so the pin can be released to its idle level while the counter keeps running. A shutdown-mode bit chooses whether the release happens at once or only when the running period ends. A one-cycle pulse marks each completed period. To park the pin, software sets the compare value at or above the period value.

Top module: `pwmt_channel`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge), the counter, compare, period and control registers read 0, pwm_out is 0 and period_done is 0.
- R2: A write (wr_en high at a rising edge) loads wr_data into the register that wr_addr selects: 0 counter, 1 compare, 2 period, 3 control. rd_data shows the register that rd_addr selects in the same cycle. Control keeps bits [6:0] and reads 0 in bits [15:7]. Control bits are [2:0] prescale select, [3] invert, [4] output enable, [5] counter enable, [6] abrupt shutdown.
- R3: With counter enable set and prescale select 0, the counter adds one on every clock. On the tick where it equals the period value, it returns to 0.
- R4: A prescale select n from 0 to 5 produces a tick every 4^n clocks. The divider is held clear while counter enable is 0, so the first count step comes 4^n clocks after the enabling write.
- R5: While output enable is set, the output is active when compare <= counter < period and inactive otherwise. A nonzero compare value therefore makes each period start inactive.
- R6: When compare >= period, the output never becomes active and stays at its idle level.
- R7: The active level is 1 and the idle level is 0 when invert is 0. Both are swapped when invert is 1, and this also applies while output enable is 0.
- R8: period_done is high for exactly one clock, in the cycle after a tick on which the counter equalled a nonzero period value. A counter write in the same cycle suppresses it.
- R9: When the period value is 0, a counter at 0 stays at 0, period_done stays low and the output stays idle.
- R10: Clearing output enable while abrupt shutdown is 1 puts the pin at its idle level in the cycle right after that write.
- R11: Clearing output enable while abrupt shutdown is 0 lets the pin follow the waveform until the current period wraps. After that the pin is idle. The counter keeps running.
- R12: A counter write takes priority over a tick in the same cycle, and counting resumes from the written value.
- R13: While counter enable is 0, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register select |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read register select |
| rd_data | output | 16 | Read data, combinational |
| pwm_out | output | 1 | Modulated output pin |
| period_done | output | 1 | One-cycle pulse after each completed period |

## Verification
The case hardest to reach from the ports is a graceful release. Output enable has to be cleared part way through the active phase, and the pin then has to stay active until the wrap and go idle only afterwards. The bench starts the counter with prescale 0 so that each clock maps to one known count value. It clears output enable at a chosen count, then samples the pin before the wrap and again at the matching count in the following period, where it would have been active. The prescaler's first-tick delay is checked the same way, by reading the counter back at the exact clocks on either side of the expected step.

// File: rtl/pwmt_pkg.sv
// Shared types for the prescaled PWM timer channel.
// Assumes the control word layout below is the one software programs.
package pwmt_pkg;
    localparam int SEL_W = 3;

    typedef enum logic [1:0] {
        ADDR_COUNT  = 2'd0,
        ADDR_CMP    = 2'd1,
        ADDR_PERIOD = 2'd2,
        ADDR_CTRL   = 2'd3
    } pwmt_addr_e;

    // Control word, most significant field first: bit 6 down to bit 0.
    typedef struct packed {
        logic             abrupt;
        logic             cnt_en;
        logic             out_en;
        logic             invert;
        logic [SEL_W-1:0] sel;
    } pwmt_ctrl_t;

    localparam int CTRL_W = $bits(pwmt_ctrl_t);
endpackage

// File: rtl/pwmt_regs.sv
// Register file for compare, period and control, plus the read mux.
// Assumes: the counter itself lives in pwmt_counter. This module only
// decodes a counter write and returns the live counter value on reads.
module pwmt_regs
    import pwmt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    input  logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] period,
    output pwmt_ctrl_t       ctrl,
    output logic             count_wr,
    output logic [CNT_W-1:0] rd_data
);
    pwmt_addr_e wa;
    pwmt_addr_e ra;
    logic       ctrl_hi_unused;

    assign wa             = pwmt_addr_e'(wr_addr);
    assign ra             = pwmt_addr_e'(rd_addr);
    assign ctrl_hi_unused = ^wr_data[CNT_W-1:CTRL_W];

    // Counter write strobe, handed to the counter.
    assign count_wr = wr_en && (wa == ADDR_COUNT);

    // Holds compare, period and control values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp    <= '0;
            period <= '0;
            ctrl   <= '0;
        end else if (wr_en) begin
            case (wa)
                ADDR_CMP:    cmp    <= wr_data;
                ADDR_PERIOD: period <= wr_data;
                ADDR_CTRL:   ctrl   <= pwmt_ctrl_t'(wr_data[CTRL_W-1:0]);
                default:     ;
            endcase
        end
    end

    // Selects the register shown on the read port.
    always_comb begin
        case (ra)
            ADDR_COUNT:  rd_data = count;
            ADDR_CMP:    rd_data = cmp;
            ADDR_PERIOD: rd_data = period;
            default:     rd_data = CNT_W'(ctrl);
        endcase
    end

    // R2: a compare write lands in the next cycle.
    a_r2_cmp_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wa == ADDR_CMP) |=> (cmp == $past(wr_data)));
    // R2: a period write lands in the next cycle.
    a_r2_period_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wa == ADDR_PERIOD) |=> (period == $past(wr_data)));
endmodule

// File: rtl/pwmt_prescaler.sv
// Power-of-four clock-enable generator.
// Assumes sel values above MAX_SEL are treated as MAX_SEL. The divider is
// held clear while en is low, so a fresh start always waits a full interval.
module pwmt_prescaler
    import pwmt_pkg::*;
#(
    parameter int MAX_SEL = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int DIV_W = 2 * MAX_SEL;

    logic [SEL_W-1:0] sel_eff;
    logic [DIV_W:0]   span;
    logic [DIV_W-1:0] limit;
    logic [DIV_W-1:0] div_cnt;

    // Clamps the select to the largest supported ratio.
    assign sel_eff = (sel > SEL_W'(MAX_SEL)) ? SEL_W'(MAX_SEL) : sel;

    // Terminal count of the divider: 4^sel - 1.
    always_comb begin
        span  = (DIV_W+1)'(1) << (2 * sel_eff);
        limit = DIV_W'(span - (DIV_W+1)'(1));
    end

    assign tick = en && (div_cnt == limit);

    // Counts clocks between ticks; cleared while disabled and on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || tick) div_cnt <= '0;
        else                       div_cnt <= div_cnt + 1'b1;
    end

    // R4: with a nonzero select, two ticks are never adjacent.
    a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sel_eff != '0 && $stable(sel_eff)) |=> !tick);
endmodule

// File: rtl/pwmt_counter.sv
// Up-counter with period wrap and period-complete pulse.
// Assumes tick comes from the prescaler and is only high while enabled.
module pwmt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cnt_en,
    input  logic             wr,
    input  logic [CNT_W-1:0] wr_val,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count,
    output logic             wrap,
    output logic             done
);
    logic at_end;

    assign at_end = (count == period);
    assign wrap   = tick && !wr && at_end && (period != '0);

    // Advances, wraps or loads the counter; a write wins over a tick.
    always_ff @(posedge clk) begin
        if (!rst_n)       count <= '0;
        else if (wr)      count <= wr_val;
        else if (tick)    count <= at_end ? '0 : count + 1'b1;
    end

    // Registers the period-complete pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= wrap;
    end

    // R3: an ordinary tick moves the counter up by one.
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr && !at_end) |=> (count == $past(count) + 1'b1));
    // R13: a stopped counter holds unless written.
    a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !wr) |=> $stable(count));
    // R9: a zero period keeps a zero counter at zero.
    a_r9_zero_period: assert property (@(posedge clk) disable iff (!rst_n)
        (period == '0 && count == '0 && !wr) |=> (count == '0));
    // R8: the pulse is one clock wide.
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/pwmt_output.sv
// Compare logic, polarity and output-enable gating with shutdown modes.
// Assumes wrap marks the last tick of a period. Graceful release waits for
// it, abrupt release acts at once, and a stopped counter releases at once.
module pwmt_output
    import pwmt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cmp,
    input  logic [CNT_W-1:0] period,
    input  pwmt_ctrl_t       ctrl,
    input  logic             wrap,
    output logic             pin
);
    logic gate_q;
    logic gate;
    logic active;

    // Active phase: from compare up to, not including, the period value.
    assign active = (count >= cmp) && (count < period);

    // Effective gate: on while enabled, or while a graceful release is pending.
    assign gate = ctrl.out_en || (gate_q && ctrl.cnt_en && !ctrl.abrupt);

    // Remembers that the output was live until the period ends.
    always_ff @(posedge clk) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= ctrl.out_en || (gate && !wrap);
    end

    assign pin = ctrl.invert ^ (gate && active);

    // R10: abrupt release leaves the pin idle.
    a_r10_abrupt_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.out_en && ctrl.abrupt) |-> (pin == ctrl.invert));
    // R6: a parked compare value keeps the pin idle.
    a_r6_parked: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp >= period) |-> (pin == ctrl.invert));
    // R11: after a graceful wrap with output disabled, the pin is idle.
    a_r11_release: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !ctrl.out_en && $stable(ctrl)) |=> (pin == $past(ctrl.invert)));
endmodule

// File: rtl/pwmt_channel.sv
// Top of the prescaled PWM timer channel: register port, prescaler,
// counter and output stage. Assumes a single clock domain and
// synchronous active-low reset.
module pwmt_channel
    import pwmt_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int MAX_SEL = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    output logic             pwm_out,
    output logic             period_done
);
    logic [CNT_W-1:0] cmp;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] count;
    pwmt_ctrl_t       ctrl;
    logic             count_wr;
    logic             tick;
    logic             wrap;

    pwmt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .count    (count),
        .cmp      (cmp),
        .period   (period),
        .ctrl     (ctrl),
        .count_wr (count_wr),
        .rd_data  (rd_data)
    );

    pwmt_prescaler #(.MAX_SEL(MAX_SEL)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ctrl.cnt_en),
        .sel   (ctrl.sel),
        .tick  (tick)
    );

    pwmt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .cnt_en (ctrl.cnt_en),
        .wr     (count_wr),
        .wr_val (wr_data),
        .period (period),
        .count  (count),
        .wrap   (wrap),
        .done   (period_done)
    );

    pwmt_output #(.CNT_W(CNT_W)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .count  (count),
        .cmp    (cmp),
        .period (period),
        .ctrl   (ctrl),
        .wrap   (wrap),
        .pin    (pwm_out)
    );
endmodule

// File: tb/tb_pwmt_channel.sv
`timescale 1ns/1ps
module tb_pwmt_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        pwm_out;
    logic        period_done;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pwmt_channel dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pwm_out(pwm_out), .period_done(period_done)
    );

    // Vector table: compare, period, invert, expected active cycles per period.
    localparam int NV = 6;
    localparam logic [15:0] V_CMP [NV] = '{16'd3, 16'd0, 16'd5, 16'd7, 16'd2, 16'd1};
    localparam logic [15:0] V_PER [NV] = '{16'd9, 16'd5, 16'd5, 16'd5, 16'd7, 16'd2};
    localparam logic        V_INV [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
    localparam int          V_ACT [NV] = '{6, 5, 0, 0, 5, 1};

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Called at a negedge; the write happens at the following rising edge.
    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    function automatic logic [15:0] mk(input int sel, input bit inv, input bit oe,
                                       input bit en, input bit ab);
        return {9'd0, ab, en, oe, inv, 3'(sel)};
    endfunction

    task automatic start(input logic [15:0] c, input logic [15:0] p, input logic [15:0] ctl);
        wr(2'd3, 16'd0);
        wr(2'd0, 16'd0);
        wr(2'd1, c);
        wr(2'd2, p);
        wr(2'd3, ctl);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [15:0] c1;
        int n;
        int ok;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 pin", int'(pwm_out), 0);
        chk("R1 done", int'(period_done), 0);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R1 reg", int'(v), 0);
        end
        @(negedge clk);

        // R2: write and read back
        wr(2'd1, 16'h1234);
        rd(2'd1, v); chk("R2 compare", int'(v), 'h1234);
        @(negedge clk);
        wr(2'd3, 16'hFF05);
        rd(2'd3, v); chk("R2 control", int'(v), 'h0005);
        @(negedge clk);

        // R5 R6 R7: table of waveforms at prescale 0
        for (int i = 0; i < NV; i++) begin
            wr(2'd3, mk(0, V_INV[i], 0, 0, 0));
            chk("R7 idle level", int'(pwm_out), int'(V_INV[i]));
            start(V_CMP[i], V_PER[i], mk(0, V_INV[i], 1, 1, 0));
            if (V_CMP[i] != 16'd0)
                chk("R5 starts inactive", int'(pwm_out), int'(V_INV[i]));
            n = (pwm_out != V_INV[i]) ? 1 : 0;
            for (int k = 1; k <= int'(V_PER[i]); k++) begin
                @(negedge clk);
                if (pwm_out != V_INV[i]) n++;
            end
            chk((V_CMP[i] >= V_PER[i]) ? "R6 parked" : "R5 active cycles", n, V_ACT[i]);
        end

        // R3 R8: count sequence and period pulse, period 3, compare parked
        start(16'd9, 16'd3, mk(0, 0, 1, 1, 0));
        ok = 1; n = 0;
        for (int k = 0; k < 8; k++) begin
            if (k > 0) @(negedge clk);
            rd(2'd0, v);
            if (int'(v) != k % 4) ok = 0;
            if (period_done) n++;
            if (k == 4) chk("R8 pulse at wrap", int'(period_done), 1);
        end
        chk("R3 count sequence", ok, 1);
        chk("R8 single pulse", n, 1);
        @(negedge clk);

        // R4: prescale 1 and 2, first step after a full interval
        start(16'd0, 16'hFFFF, mk(1, 0, 0, 1, 0));
        repeat (3) @(negedge clk);
        rd(2'd0, v); chk("R4 sel1 k3", int'(v), 0);
        @(negedge clk);
        rd(2'd0, v); chk("R4 sel1 k4", int'(v), 1);
        repeat (4) @(negedge clk);
        rd(2'd0, v); chk("R4 sel1 k8", int'(v), 2);
        @(negedge clk);
        start(16'd0, 16'hFFFF, mk(2, 0, 0, 1, 0));
        repeat (15) @(negedge clk);
        rd(2'd0, v); chk("R4 sel2 k15", int'(v), 0);
        @(negedge clk);
        rd(2'd0, v); chk("R4 sel2 k16", int'(v), 1);
        @(negedge clk);

        // R12: counter write while running
        start(16'd0, 16'hFFFF, mk(0, 0, 0, 1, 0));
        repeat (3) @(negedge clk);
        wr(2'd0, 16'h0100);
        rd(2'd0, v); chk("R12 written", int'(v), 'h0100);
        @(negedge clk);
        rd(2'd0, v); chk("R12 resumes", int'(v), 'h0101);
        @(negedge clk);

        // R13: stopping freezes the counter
        wr(2'd3, mk(0, 0, 0, 0, 0));
        rd(2'd0, c1);
        repeat (5) @(negedge clk);
        rd(2'd0, v); chk("R13 hold", int'(v), int'(c1));
        @(negedge clk);

        // R9: zero period
        start(16'd0, 16'd0, mk(0, 0, 1, 1, 0));
        ok = 1;
        for (int k = 0; k < 10; k++) begin
            rd(2'd0, v);
            if (v != 16'd0 || period_done || pwm_out) ok = 0;
            @(negedge clk);
        end
        chk("R9 zero period", ok, 1);

        // R10: abrupt release mid active phase
        start(16'd3, 16'd9, mk(0, 0, 1, 1, 0));
        repeat (5) @(negedge clk);
        chk("R10 active before", int'(pwm_out), 1);
        wr(2'd3, mk(0, 0, 0, 1, 1));
        chk("R10 idle at once", int'(pwm_out), 0);
        rd(2'd0, v); chk("R10 counter runs", int'(v), 6);
        @(negedge clk);

        // R11: graceful release waits for the wrap
        start(16'd3, 16'd9, mk(0, 0, 1, 1, 0));
        repeat (5) @(negedge clk);
        wr(2'd3, mk(0, 0, 0, 1, 0));
        chk("R11 still active k6", int'(pwm_out), 1);
        repeat (2) @(negedge clk);
        chk("R11 still active k8", int'(pwm_out), 1);
        repeat (5) @(negedge clk);
        chk("R11 idle next period", int'(pwm_out), 0);
        rd(2'd0, v); chk("R11 counter runs", int'(v), 3);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule